// File: doc/BRIEF.md
# SHA-256 Stream Engine

This block is an iterative SHA-256 compression engine. Software, or a data mover, first issues a start command. It then pushes whole, already padded 512-bit blocks into the engine as sixteen 32-bit words through a single data register. The engine performs one compression round for every word accepted, and the message schedule is filled straight from the bus. There is no input FIFO.

When the sixteenth word of a block arrives, the engine runs the remaining 48 rounds on its own. It then adds the working variables into the 256-bit running digest. It holds its ready flag low for a fixed window while this happens. Consecutive blocks chain into the same digest until the next start command. Eight read-only registers present the digest, most significant word first.

A small register port carries the control/status word, the data register and the digest words. The control/status word holds four things: a self-clearing start bit, the ready and digest-valid flags, a sticky error flag that records data writes rejected while busy, and two plain configuration fields. One field is a transfer-size code stored for a neighbouring data mover. The other is a byte-reversal enable applied to each word as it enters the schedule.

Top module: `sha256_stream_engine`

## Requirements
- R1: After reset the control/status word at offset 0x00 reads 0x1206. Its fields are: bit 0 start (always reads 0), bit 1 ready, bit 2 digest valid, bit 4 write error, bits 9:8 transfer-size code, bit 12 byte reversal.
- R2: Writing 1 to bit 0 of the control/status word loads the SHA-256 initial hash values into the digest words and discards any partly written block.
- R3: In the cycle after a start command, ready and digest valid both read 1.
- R4: Digest valid reads 0 from the acceptance of the first word of a block until that block's digest update finishes. It becomes 1 in the same cycle that ready returns to 1.
- R5: After the sixteenth word of a block is accepted, ready reads 0 for exactly 57 consecutive clock cycles and then reads 1.
- R6: A write to the data register (offset 0x04) while ready is 0 sets the error bit and is otherwise ignored: it neither counts as a word nor changes the digest.
- R7: The error bit stays set until a control/status write with bit 4 equal to 1. A write with bit 4 equal to 0 leaves it unchanged.
- R8: Once a block completes, the digest words at offsets 0x08 through 0x24 (word 0 the most significant) equal the SHA-256 compression of that block. The compression is applied to the digest that was present before the block.
- R9: Successive blocks chain: each block's compression starts from the digest left by the previous block, until the next start command.
- R10: When bit 12 is 1, each data word is byte-reversed (bits 7:0 become bits 31:24) before it enters the schedule. When bit 12 is 0, the word is used unchanged.
- R11: Bits 9:8 and bit 12 of the control/status word read back the values last written there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe for one cycle |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The hardest situation to provoke is a data write that lands inside the 57-cycle busy window. The write must set the error flag, yet leave both the word count and the digest untouched. The bench issues such a write right after a sixteenth word and confirms that the final digest still matches a known vector. A start command issued in the middle of a block is reached the same way: the bench writes a few random words, restarts, and checks that a fresh block still hashes correctly. The bench also uses random multi-block messages in both byte orders, each compared against a reference model inside the bench.

// File: rtl/sha256_eng_pkg.sv
package sha256_eng_pkg;

    typedef logic [31:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
        word_t h;
    } state_t;

    localparam int BLOCK_WORDS = 16;
    localparam int ROUND_COUNT = 64;
    localparam int EXP_ROUNDS  = ROUND_COUNT - BLOCK_WORDS;

    // register offsets and control/status bit positions
    localparam logic [5:0] OFS_CTRL = 6'h00;
    localparam logic [5:0] OFS_DATA = 6'h04;
    localparam logic [5:0] OFS_HASH = 6'h08;
    localparam int BIT_GO    = 0;
    localparam int BIT_RDY   = 1;
    localparam int BIT_VLD   = 2;
    localparam int BIT_ERR   = 4;
    localparam int BIT_SZ_LO = 8;
    localparam int BIT_SWAP  = 12;

    localparam word_t ROUND_K [ROUND_COUNT] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
        32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
        32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
        32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
        32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
        32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
        32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
        32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
        32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    function automatic state_t init_hash();
        state_t s;
        s.a = 32'h6a09e667; s.b = 32'hbb67ae85;
        s.c = 32'h3c6ef372; s.d = 32'ha54ff53a;
        s.e = 32'h510e527f; s.f = 32'h9b05688c;
        s.g = 32'h1f83d9ab; s.h = 32'h5be0cd19;
        return s;
    endfunction

    function automatic word_t round_const(logic [5:0] idx);
        return ROUND_K[idx];
    endfunction

    function automatic word_t rotr(word_t x, int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic word_t sig_big0(word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t sig_big1(word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t sig_small0(word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t sig_small1(word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic word_t byte_rev(word_t x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    function automatic state_t add_state(state_t x, state_t y);
        state_t r;
        r.a = x.a + y.a; r.b = x.b + y.b; r.c = x.c + y.c; r.d = x.d + y.d;
        r.e = x.e + y.e; r.f = x.f + y.f; r.g = x.g + y.g; r.h = x.h + y.h;
        return r;
    endfunction

endpackage

// File: rtl/sha256_eng_sched.sv
module sha256_eng_sched
    import sha256_eng_pkg::*;
#(
    parameter int DEPTH = BLOCK_WORDS
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  shift_in,
    input  logic  expand,
    input  word_t in_word,
    output word_t w_cur
);

    localparam int TAP_M2  = DEPTH - 2;
    localparam int TAP_M7  = DEPTH - 7;
    localparam int TAP_M15 = DEPTH - 15;

    word_t hist_q [DEPTH];

    always_comb begin
        if (shift_in) begin
            w_cur = in_word;
        end else begin
            w_cur = sig_small1(hist_q[TAP_M2]) + hist_q[TAP_M7]
                  + sig_small0(hist_q[TAP_M15]) + hist_q[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
        end else if (shift_in || expand) begin
            for (int i = 0; i < DEPTH - 1; i++) hist_q[i] <= hist_q[i + 1];
            hist_q[DEPTH - 1] <= w_cur;
        end
    end

    // R8: a schedule slot is fed either from the bus or from expansion, never both
    assert_single_source_R8: assert property (@(posedge clk) disable iff (rst)
        !(shift_in && expand));

endmodule

// File: rtl/sha256_eng_round.sv
module sha256_eng_round
    import sha256_eng_pkg::*;
(
    input  state_t s_in,
    input  word_t  k_in,
    input  word_t  w_in,
    output state_t s_out
);

    word_t t1;
    word_t t2;
    word_t ch;
    word_t maj;

    always_comb begin
        ch    = (s_in.e & s_in.f) ^ (~s_in.e & s_in.g);
        maj   = (s_in.a & s_in.b) ^ (s_in.a & s_in.c) ^ (s_in.b & s_in.c);
        t1    = s_in.h + sig_big1(s_in.e) + ch + k_in + w_in;
        t2    = sig_big0(s_in.a) + maj;
        s_out.a = t1 + t2;
        s_out.b = s_in.a;
        s_out.c = s_in.b;
        s_out.d = s_in.c;
        s_out.e = s_in.d + t1;
        s_out.f = s_in.e;
        s_out.g = s_in.f;
        s_out.h = s_in.g;
    end

endmodule

// File: rtl/sha256_eng_ctrl.sv
module sha256_eng_ctrl
    import sha256_eng_pkg::*;
#(
    parameter int BUSY_CYCLES = 57
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       data_wr,
    input  logic       err_clr,
    output logic       rdy,
    output logic       vld,
    output logic       err,
    output logic       accept,
    output logic       expand,
    output logic       fold,
    output logic       first_word,
    output logic [5:0] rnd
);

    localparam int BW   = $clog2(BUSY_CYCLES + 1);
    localparam int TAIL = BUSY_CYCLES - EXP_ROUNDS;

    logic [BW-1:0] busy_q;
    logic [5:0]    rnd_q;
    logic          vld_q;
    logic          err_q;

    assign rdy        = (busy_q == '0);
    assign accept     = data_wr && rdy;
    assign expand     = (busy_q > BW'(TAIL));
    assign fold       = (busy_q == BW'(1));
    assign first_word = (rnd_q == 6'd0);
    assign rnd        = rnd_q;
    assign vld        = vld_q;
    assign err        = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
            rnd_q  <= '0;
            vld_q  <= 1'b1;
        end else if (start) begin
            busy_q <= '0;
            rnd_q  <= '0;
            vld_q  <= 1'b1;
        end else if (accept) begin
            rnd_q <= rnd_q + 6'd1;
            if (first_word) vld_q <= 1'b0;
            if (rnd_q == 6'(BLOCK_WORDS - 1)) busy_q <= BW'(BUSY_CYCLES);
        end else if (busy_q != '0) begin
            busy_q <= busy_q - BW'(1);
            if (expand) rnd_q <= rnd_q + 6'd1;
            if (fold) vld_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (data_wr && !rdy) begin
            err_q <= 1'b1;
        end else if (err_clr) begin
            err_q <= 1'b0;
        end
    end

    // checker state: length of the current low run of ready
    logic [BW:0] low_run;
    always_ff @(posedge clk) begin
        if (rst || rdy) low_run <= '0;
        else            low_run <= low_run + 1'b1;
    end

    assert_start_flags_R3: assert property (@(posedge clk) disable iff (rst)
        start |=> (rdy && vld));

    assert_first_word_drops_valid_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && first_word && !start) |=> !vld);

    assert_valid_with_ready_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(vld) && !$past(start)) |-> rdy);

    assert_ready_falls_on_word_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy) |-> $past(accept));

    assert_busy_window_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(rdy) && !$past(start)) |-> (low_run == (BW+1)'(BUSY_CYCLES)));

    assert_err_sets_R6: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !rdy) |=> err);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (err && !err_clr) |=> err);

endmodule

// File: rtl/sha256_stream_engine.sv
module sha256_stream_engine
    import sha256_eng_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int BUSY_CYCLES = 57
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    localparam int HASH_WORDS = 8;

    logic       wr_ctrl;
    logic       wr_data;
    logic       start;
    logic       err_clr;
    logic       swap_q;
    logic [1:0] size_q;
    word_t      word_in;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_data = bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
    assign start   = wr_ctrl && bus_wdata[BIT_GO];
    assign err_clr = wr_ctrl && bus_wdata[BIT_ERR];
    assign word_in = swap_q ? byte_rev(bus_wdata) : bus_wdata;

    logic       rdy, vld, err, accept, expand, fold, first_word;
    logic [5:0] rnd;

    sha256_eng_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .data_wr    (wr_data),
        .err_clr    (err_clr),
        .rdy        (rdy),
        .vld        (vld),
        .err        (err),
        .accept     (accept),
        .expand     (expand),
        .fold       (fold),
        .first_word (first_word),
        .rnd        (rnd)
    );

    word_t w_cur;

    sha256_eng_sched #(.DEPTH(BLOCK_WORDS)) u_sched (
        .clk      (clk),
        .rst      (rst),
        .shift_in (accept),
        .expand   (expand),
        .in_word  (word_in),
        .w_cur    (w_cur)
    );

    state_t hash_q;
    state_t work_q;
    state_t round_in;
    state_t round_out;

    assign round_in = first_word ? hash_q : work_q;

    sha256_eng_round u_round (
        .s_in  (round_in),
        .k_in  (round_const(rnd)),
        .w_in  (w_cur),
        .s_out (round_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hash_q <= init_hash();
            work_q <= '0;
            swap_q <= 1'b1;
            size_q <= 2'd2;
        end else begin
            if (start)      hash_q <= init_hash();
            else if (fold)  hash_q <= add_state(hash_q, work_q);
            if (accept || expand) work_q <= round_out;
            if (wr_ctrl) begin
                swap_q <= bus_wdata[BIT_SWAP];
                size_q <= bus_wdata[BIT_SZ_LO +: 2];
            end
        end
    end

    logic [HASH_WORDS*32-1:0] hash_flat;
    assign hash_flat = hash_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CTRL)) begin
            bus_rdata[BIT_RDY]          = rdy;
            bus_rdata[BIT_VLD]          = vld;
            bus_rdata[BIT_ERR]          = err;
            bus_rdata[BIT_SZ_LO +: 2]   = size_q;
            bus_rdata[BIT_SWAP]         = swap_q;
        end
        for (int i = 0; i < HASH_WORDS; i++) begin
            if (bus_addr == ADDR_W'(int'(OFS_HASH) + 4 * i))
                bus_rdata = hash_flat[HASH_WORDS*32-1-32*i -: 32];
        end
    end

    assert_start_loads_init_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (hash_q == init_hash()));

    assert_hash_held_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (!start && !fold) |=> $stable(hash_q));

endmodule

// File: tb/test_sha256_stream_engine.sv
module test_sha256_stream_engine;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sha256_stream_engine i_sha256_stream_engine (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    localparam logic [255:0] IV_HASH =
        256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;
    localparam logic [255:0] EMPTY_HASH =
        256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855;
    localparam logic [255:0] ABC_HASH =
        256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
    localparam logic [255:0] TWO_BLK_HASH =
        256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1;

    localparam logic [31:0] KT [64] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
        32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
        32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
        32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
        32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
        32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
        32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
        32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
        32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    function automatic logic [31:0] rr(logic [31:0] x, int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [31:0] flip(logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    // reference compression of one block onto a running hash
    function automatic logic [255:0] ref_block(logic [255:0] h_in, logic [511:0] blk);
        logic [31:0] w [64];
        logic [31:0] v [8];
        logic [31:0] t1, t2;
        for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
        for (int i = 16; i < 64; i++)
            w[i] = (rr(w[i-2], 17) ^ rr(w[i-2], 19) ^ (w[i-2] >> 10)) + w[i-7]
                 + (rr(w[i-15], 7) ^ rr(w[i-15], 18) ^ (w[i-15] >> 3)) + w[i-16];
        for (int i = 0; i < 8; i++) v[i] = h_in[255-32*i -: 32];
        for (int i = 0; i < 64; i++) begin
            t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
               + ((v[4] & v[5]) ^ (~v[4] & v[6])) + KT[i] + w[i];
            t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
               + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
            for (int j = 7; j > 0; j--) v[j] = v[j-1];
            v[4] = v[4] + t1;
            v[0] = t1 + t2;
        end
        for (int i = 0; i < 8; i++) h_in[255-32*i -: 32] = h_in[255-32*i -: 32] + v[i];
        return h_in;
    endfunction

    task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic read_hash(output logic [255:0] h);
        logic [31:0] d;
        for (int i = 0; i < 8; i++) begin
            bus_read(6'(8 + 4*i), d);
            h[255-32*i -: 32] = d;
        end
    endtask

    // returns the number of cycles ready was seen low
    task automatic wait_ready(output int low);
        logic [31:0] c;
        low = 0;
        bus_read(6'h00, c);
        while (!c[1] && low < 1000) begin
            low++;
            @(negedge clk);
            bus_read(6'h00, c);
        end
    endtask

    task automatic send_block(logic [511:0] blk, bit sw);
        logic [31:0] wd;
        int low;
        for (int i = 0; i < 16; i++) begin
            wd = blk[511-32*i -: 32];
            bus_write(6'h04, sw ? flip(wd) : wd);
        end
        wait_ready(low);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0]  c;
        logic [255:0] h, exp_h;
        logic [511:0] blk, blk_a, blk_b, empty_blk, abc_blk;
        int low;

        void'($urandom(32'd20240611));
        empty_blk = {32'h80000000, 480'h0};
        abc_blk   = {32'h61626380, 448'h0, 32'h18};
        for (int i = 0; i < 14; i++)
            blk_a[511-32*i -: 32] = {8'(8'h61+i), 8'(8'h62+i), 8'(8'h63+i), 8'(8'h64+i)};
        blk_a[63:0] = {32'h80000000, 32'h0};
        blk_b = 512'h1c0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset value of the control/status word
        bus_read(6'h00, c);
        chk("R1 reset ctrl word", 256'(c), 256'h1206);

        // R2 R3 R11: start with byte reversal on, start bit reads back 0
        bus_write(6'h00, 32'h1201);
        bus_read(6'h00, c);
        chk("R3 ready/valid after start, R11 start reads 0", 256'(c), 256'h1206);
        read_hash(h);
        chk("R2 initial hash after start", h, IV_HASH);

        // R4 R5 R8 R10: empty message with byte-reversed words
        bus_write(6'h04, flip(empty_blk[511:480]));
        bus_read(6'h00, c);
        chk("R4 valid low ready high after first word", 256'(c[2:1]), 256'b01);
        for (int i = 1; i < 16; i++) bus_write(6'h04, flip(empty_blk[511-32*i -: 32]));
        bus_read(6'h00, c);
        chk("R4 valid low during busy", 256'(c[2]), 256'b0);
        wait_ready(low);
        chk("R5 ready low cycles", 256'(low), 256'd57);
        bus_read(6'h00, c);
        chk("R4 valid and ready back", 256'(c[2:1]), 256'b11);
        read_hash(h);
        chk("R8 R10 empty message hash", h, EMPTY_HASH);

        // R9 R10: two-block message with byte reversal off
        bus_write(6'h00, 32'h0201);
        send_block(blk_a, 1'b0);
        read_hash(h);
        chk("R9 intermediate hash", h, ref_block(IV_HASH, blk_a));
        send_block(blk_b, 1'b0);
        read_hash(h);
        chk("R9 two-block hash", h, TWO_BLK_HASH);

        // R6 R7: write during busy window
        bus_write(6'h00, 32'h0201);
        for (int i = 0; i < 16; i++) bus_write(6'h04, abc_blk[511-32*i -: 32]);
        bus_write(6'h04, 32'hdeadbeef);
        bus_read(6'h00, c);
        chk("R6 error set by busy write", 256'(c[4]), 256'b1);
        wait_ready(low);
        read_hash(h);
        chk("R6 busy write ignored", h, ABC_HASH);
        bus_write(6'h00, 32'h0200);
        bus_read(6'h00, c);
        chk("R7 error kept on zero write", 256'(c[4]), 256'b1);
        bus_write(6'h00, 32'h0210);
        bus_read(6'h00, c);
        chk("R7 error cleared", 256'(c[4]), 256'b0);

        // R2 R3: restart in the middle of a block
        bus_write(6'h00, 32'h0201);
        for (int i = 0; i < 5; i++) bus_write(6'h04, $urandom);
        bus_write(6'h00, 32'h0201);
        bus_read(6'h00, c);
        chk("R3 flags after mid-block start", 256'(c[2:1]), 256'b11);
        read_hash(h);
        chk("R2 init hash after mid-block start", h, IV_HASH);
        send_block(abc_blk, 1'b0);
        read_hash(h);
        chk("R2 partial block discarded", h, ABC_HASH);

        // R11: configuration fields read back
        bus_write(6'h00, 32'h0100);
        bus_read(6'h00, c);
        chk("R11 size field 1 swap 0", 256'({c[12], c[9:8]}), 256'b001);
        bus_write(6'h00, 32'h1000);
        bus_read(6'h00, c);
        chk("R11 size field 0 swap 1", 256'({c[12], c[9:8]}), 256'b100);

        // R8 R9 R10: random multi-block messages
        for (int it = 0; it < 8; it++) begin
            bit sw;
            int nb;
            sw = 1'($urandom % 2);
            nb = 1 + int'($urandom % 3);
            bus_write(6'h00, {19'h0, sw, 3'h0, 2'd2, 7'h01});
            exp_h = IV_HASH;
            for (int b = 0; b < nb; b++) begin
                for (int i = 0; i < 16; i++) blk[511-32*i -: 32] = $urandom;
                send_block(blk, sw);
                exp_h = ref_block(exp_h, blk);
                read_hash(h);
                chk(sw ? "R8 R9 R10 random swapped" : "R8 R9 random plain", h, exp_h);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule